// File: doc/BRIEF.md
# Preamble-Framed Serial Transmitter with Switchable CRC-32

This block turns a stream of bytes taken from a transmit FIFO into one serial bit per clock for an Ethernet-style link. A start strobe launches a frame. The block first sends a fixed header of alternating preamble bits and a closing sync byte. It then shifts out the number of payload bytes given on the byte-count input, popping each one from a show-ahead FIFO. Last, it either appends a hardware CRC-32 frame check sequence, or it stops after the last payload byte so that software can place its own check sequence at the end of the payload.

A down-counter shows how many payload bytes are still to be fetched. When the final bit has left the line, a sticky transmit-done flag is raised for the interrupt logic. Software clears it by pulsing a clear input. If the FIFO runs dry before a payload byte is due, the line enable drops and the frame resumes, without losing any bits, once data is present again.

Top module: `frame_serializer`

## Requirements
- R1: While reset (`rst_n` low) is held and after it, until a frame starts, `ser_en`, `fifo_rd` and `done_flag` are 0 and `bytes_left` is 0.
- R2: A `start` seen while idle makes `ser_en` 1 from the next cycle. The first 64 line bits are 56 bits alternating 1,0,... starting with 1, then the sync bits 1,0,1,0,1,0,1,1. This is bytes 0x55 x7 then 0xD5, each sent LSB first.
- R3: Payload bytes are sent in FIFO order, least significant bit first. There is exactly one `fifo_rd` pulse per payload byte, and `fifo_rd` is never 1 while `fifo_empty` is 1 or while idle.
- R4: With `crc_inhibit` = 0 at start, 32 FCS bits follow the payload. The FCS is the complement of a CRC-32 with polynomial 0x04C11DB7 (processed bit-reflected), preset to all ones, taken over the payload bits in line order. Its low byte is sent first, LSB first. Payload "123456789" gives 0xCBF43926.
- R5: With `crc_inhibit` = 1 at start, the last line bit is bit 7 of the last FIFO byte, and the frame is exactly 64 + 8*N bits long.
- R6: `bytes_left` loads `byte_count` at start and drops by exactly 1 in the cycle after each `fifo_rd`. It is 0 when the frame ends.
- R7: `done_flag` becomes 1 in the same cycle that `ser_en` falls at frame end. It stays 1 until a cycle with `done_clr` = 1 clears it. A frame end in the same cycle as a clear wins.
- R8: While the FIFO never runs dry, `ser_en` stays 1 without a gap for the whole frame. `start`, `byte_count` and `crc_inhibit` have no effect while a frame is in progress.
- R9: If `fifo_empty` is 1 when a payload byte is due, `ser_en` goes 0 until data is present. The frame then resumes with no bit lost or repeated.
- R10: With `byte_count` = 0, the header is followed directly by the FCS of an empty payload (32 zero bits), or by nothing when `crc_inhibit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame launch strobe, taken only when idle |
| byte_count | input | CNT_W | Payload length in bytes, sampled at start |
| crc_inhibit | input | 1 | 1: no hardware FCS appended; sampled at start |
| fifo_empty | input | 1 | Show-ahead FIFO has no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_rd | output | 1 | Pop strobe; the head byte is taken at this edge |
| ser_data | output | 1 | Serial line bit |
| ser_en | output | 1 | Line bit valid |
| bytes_left | output | CNT_W | Payload bytes still to fetch |
| done_flag | output | 1 | Sticky transmit-done interrupt flag |
| done_clr | input | 1 | Clears done_flag (write-one-to-clear pulse) |

## Verification
A wrong header or byte index shows at the ports within the byte it corrupts: a misplaced sync pattern appears at line bit 56, and a lost or doubled pop shifts every later payload bit and breaks the FCS. An error in the CRC register shows only in the 32 tail bits, so known vectors and random payloads are compared against a reference FCS. A wrong phase or counter also shows in frame length, in gaps of `ser_en`, in `bytes_left` failing to reach zero, or in `done_flag` rising a cycle early or late. Starvation and mid-frame start pulses are forced deliberately, so that the hold and ignore paths are observed at the line.

// File: rtl/fs_pkg.sv
package fs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_PAY,
      PH_WAIT,
      PH_FCS
   } fs_phase_e;

   // bit-reflected form of generator 0x04C11DB7
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   function automatic logic [31:0] crc32_byte(input logic [31:0] cur,
                                              input logic [7:0]  din);
      logic [31:0] c;
      c = cur;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY_REFL;
         else               c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/fs_shifter.sv
module fs_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_byte,
   input  logic         shift_en,
   output logic         bit_out,
   output logic         bit_last
);
   localparam int CW = $clog2(W);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= load_byte;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= sh_q >> 1;
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign bit_out  = sh_q[0];
   assign bit_last = shift_en && (cnt_q == CW'(W - 1));
endmodule

// File: rtl/fs_crc32.sv
module fs_crc32
   import fs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [31:0] fcs
);
   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= '1;
      else if (init) crc_q <= '1;
      else if (upd)  crc_q <= crc32_byte(crc_q, din);
   end

   assign fcs = ~crc_q;
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
   import fs_pkg::*;
#(
   parameter int         CNT_W     = 12,
   parameter int         PRE_BYTES = 7,
   parameter logic [7:0] PRE_PAT   = 8'h55,
   parameter logic [7:0] SYNC_PAT  = 8'hD5,
   parameter bit         HW_CRC    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] byte_count,
   input  logic             crc_inhibit,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   input  logic [31:0]      crc_value,
   input  logic             bit_last,
   input  logic             done_clr,
   output logic             load,
   output logic [7:0]       load_byte,
   output logic             line_on,
   output logic             pop,
   output logic             crc_init,
   output logic [CNT_W-1:0] bytes_left,
   output logic             busy,
   output logic             frame_end,
   output logic             done_flag
);
   localparam int HW = $clog2(PRE_BYTES + 1);

   fs_phase_e        ph_q, ph_n;
   logic [HW-1:0]    hdr_q, hdr_n;
   logic [1:0]       fcs_q, fcs_n, fcs_nx;
   logic [CNT_W-1:0] left_q, left_n;
   logic             inh_q, inh_n;
   logic             on_q, on_n;
   logic             done_q;
   logic             fetch;

   assign fcs_nx = fcs_q + 2'd1;

   always_comb begin
      ph_n      = ph_q;
      hdr_n     = hdr_q;
      fcs_n     = fcs_q;
      left_n    = left_q;
      inh_n     = inh_q;
      on_n      = on_q;
      load      = 1'b0;
      load_byte = PRE_PAT;
      pop       = 1'b0;
      crc_init  = 1'b0;
      frame_end = 1'b0;
      fetch     = 1'b0;
      case (ph_q)
         PH_IDLE: if (start) begin
            ph_n     = PH_HDR;
            hdr_n    = '0;
            left_n   = byte_count;
            inh_n    = crc_inhibit || !HW_CRC;
            on_n     = 1'b1;
            load     = 1'b1;
            crc_init = 1'b1;
         end
         PH_HDR: if (bit_last) begin
            if (hdr_q < HW'(PRE_BYTES)) begin
               hdr_n     = hdr_q + HW'(1);
               load      = 1'b1;
               load_byte = (hdr_q == HW'(PRE_BYTES - 1)) ? SYNC_PAT : PRE_PAT;
            end else begin
               fetch = 1'b1;
            end
         end
         PH_PAY:  fetch = bit_last;
         PH_WAIT: fetch = 1'b1;
         PH_FCS: if (bit_last) begin
            if (fcs_q == 2'd3) begin
               frame_end = 1'b1;
            end else begin
               fcs_n     = fcs_nx;
               load      = 1'b1;
               load_byte = crc_value[{fcs_nx, 3'b000} +: 8];
            end
         end
         default: ph_n = PH_IDLE;
      endcase

      if (fetch) begin
         if (left_q == '0) begin
            if (!inh_q) begin
               ph_n      = PH_FCS;
               fcs_n     = 2'd0;
               load      = 1'b1;
               load_byte = crc_value[7:0];
               on_n      = 1'b1;
            end else begin
               frame_end = 1'b1;
            end
         end else if (fifo_empty) begin
            ph_n = PH_WAIT;
            on_n = 1'b0;
         end else begin
            pop       = 1'b1;
            load      = 1'b1;
            load_byte = fifo_data;
            left_n    = left_q - CNT_W'(1);
            ph_n      = PH_PAY;
            on_n      = 1'b1;
         end
      end

      if (frame_end) begin
         ph_n = PH_IDLE;
         on_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         hdr_q  <= '0;
         fcs_q  <= '0;
         left_q <= '0;
         inh_q  <= 1'b0;
         on_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_n;
         hdr_q  <= hdr_n;
         fcs_q  <= fcs_n;
         left_q <= left_n;
         inh_q  <= inh_n;
         on_q   <= on_n;
         if (frame_end)     done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
      end
   end

   assign line_on    = on_q;
   assign bytes_left = left_q;
   assign busy       = (ph_q != PH_IDLE);
   assign done_flag  = done_q;
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
   import fs_pkg::*;
#(
   parameter int         CNT_W     = 12,
   parameter int         PRE_BYTES = 7,
   parameter logic [7:0] PRE_PAT   = 8'h55,
   parameter logic [7:0] SYNC_PAT  = 8'hD5,
   parameter bit         HW_CRC    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] byte_count,
   input  logic             crc_inhibit,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             fifo_rd,
   output logic             ser_data,
   output logic             ser_en,
   output logic [CNT_W-1:0] bytes_left,
   output logic             done_flag,
   input  logic             done_clr
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (PRE_BYTES >= 1 && PRE_BYTES <= 64) else $error("PRE_BYTES out of range");
   end

   logic        load, line_on, pop, crc_init, bit_last, busy, frame_end;
   logic [7:0]  load_byte;
   logic [31:0] crc_value;

   fs_ctrl #(
      .CNT_W(CNT_W), .PRE_BYTES(PRE_BYTES), .PRE_PAT(PRE_PAT),
      .SYNC_PAT(SYNC_PAT), .HW_CRC(HW_CRC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
      .crc_inhibit(crc_inhibit), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .crc_value(crc_value), .bit_last(bit_last), .done_clr(done_clr),
      .load(load), .load_byte(load_byte), .line_on(line_on), .pop(pop),
      .crc_init(crc_init), .bytes_left(bytes_left), .busy(busy),
      .frame_end(frame_end), .done_flag(done_flag)
   );

   fs_shifter #(.W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
      .shift_en(line_on), .bit_out(ser_data), .bit_last(bit_last)
   );

   if (HW_CRC) begin : g_crc
      fs_crc32 u_crc (
         .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(pop),
         .din(fifo_data), .fcs(crc_value)
      );
   end else begin : g_nocrc
      assign crc_value = '0;
   end

   assign fifo_rd = pop;
   assign ser_en  = line_on;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_rd,
   input logic             fifo_empty,
   input logic             ser_en,
   input logic [CNT_W-1:0] bytes_left,
   input logic             done_flag,
   input logic             done_clr,
   input logic             busy,
   input logic             frame_end
);
   p_rd_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);

   p_rd_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fifo_rd);

   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> bytes_left == $past(bytes_left) - CNT_W'(1));

   p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !frame_end) |=> !done_flag);

   p_line_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_en);
endmodule

bind frame_serializer fs_checker #(.CNT_W(CNT_W)) u_fs_checker (
   .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
   .ser_en(ser_en), .bytes_left(bytes_left), .done_flag(done_flag),
   .done_clr(done_clr), .busy(busy), .frame_end(frame_end)
);

// File: tb/tb_frame_serializer.sv
module tb_frame_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 12;
   localparam int WATCHDOG   = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] byte_count = '0;
   logic             crc_inhibit = 1'b0;
   logic             fifo_empty = 1'b1;
   logic [7:0]       fifo_data = 8'h00;
   logic             done_clr = 1'b0;
   logic             fifo_rd, ser_data, ser_en, done_flag;
   logic [CNT_W-1:0] bytes_left;

   frame_serializer #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
      .crc_inhibit(crc_inhibit), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .fifo_rd(fifo_rd), .ser_data(ser_data), .ser_en(ser_en),
      .bytes_left(bytes_left), .done_flag(done_flag), .done_clr(done_clr)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] fq[$];
   bit         got[$];
   bit         expb[$];
   bit         pend = 1'b0;
   bit         prev_en = 1'b0;
   logic [CNT_W-1:0] prev_left = '0;
   int on_cycles = 0;
   int gaps = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_fcs(input logic [7:0] pl[$]);
      logic [31:0] r = 32'hFFFF_FFFF;
      foreach (pl[i]) begin
         for (int b = 0; b < 8; b++) begin
            if (r[0] ^ pl[i][b]) r = (r >> 1) ^ 32'hEDB8_8320;
            else                 r = r >> 1;
         end
      end
      return ~r;
   endfunction

   function automatic int mism(input int lo, input int hi);
      int n = 0;
      for (int i = lo; i < hi; i++) begin
         if (i >= got.size() || i >= expb.size()) n++;
         else if (got[i] != expb[i]) n++;
      end
      return n;
   endfunction

   // FIFO model and line monitor, all activity at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (pend) begin
            void'(fq.pop_front());
            chk(bytes_left == CNT_W'(prev_left - 1), "R6 count step", bytes_left,
                CNT_W'(prev_left - 1));
         end
         fifo_empty = (fq.size() == 0);
         fifo_data  = (fq.size() != 0) ? fq[0] : 8'h00;
         #1;
         pend      = fifo_rd;
         prev_left = bytes_left;
         if (fifo_rd && fifo_empty) chk(1'b0, "R3 pop while empty", 1, 0);
         if (ser_en) begin
            got.push_back(ser_data);
            on_cycles++;
         end
         if (prev_en && !ser_en && !done_flag) gaps++;
         prev_en = ser_en;
         if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   task automatic run_frame(input logic [7:0] pl[$], input bit inh,
                            input bit stall, input bit poke);
      logic [31:0] f;
      int n, hold_from, t;
      bit rest_done;
      n = pl.size();
      got.delete();
      expb.delete();
      on_cycles = 0;
      gaps = 0;
      for (int k = 0; k < 8; k++)
         for (int b = 0; b < 8; b++)
            expb.push_back(k == 7 ? 8'hD5 >> b & 1 : 8'h55 >> b & 1);
      foreach (pl[i]) for (int b = 0; b < 8; b++) expb.push_back(pl[i][b]);
      f = ref_fcs(pl);
      if (!inh) for (int b = 0; b < 32; b++) expb.push_back(f[b]);
      hold_from = (stall && n >= 3) ? 2 : n;
      for (int i = 0; i < hold_from; i++) fq.push_back(pl[i]);
      rest_done = (hold_from == n);
      @(negedge clk);
      start = 1'b1;
      byte_count = CNT_W'(n);
      crc_inhibit = inh;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done_flag && t < 5000) begin
         @(negedge clk);
         #2;
         t++;
         if (poke && t == 20) begin
            start = 1'b1;
            byte_count = CNT_W'(3);
            crc_inhibit = ~inh;
         end else begin
            start = 1'b0;
            crc_inhibit = inh;
         end
         if (!rest_done && t == 150) begin
            for (int i = hold_from; i < n; i++) fq.push_back(pl[i]);
            rest_done = 1'b1;
         end
      end
      start = 1'b0;
      @(negedge clk);
      #2;
      chk(done_flag == 1'b1, "R7 done set at end", done_flag, 1);
      chk(got.size() == expb.size(), "R5 frame length", got.size(), expb.size());
      chk(mism(0, 64) == 0, "R2 header bits", mism(0, 64), 0);
      chk(mism(64, 64 + 8 * n) == 0, "R3 payload bits", mism(64, 64 + 8 * n), 0);
      if (!inh) chk(mism(64 + 8 * n, expb.size()) == 0, "R4 fcs bits",
                    mism(64 + 8 * n, expb.size()), 0);
      chk(bytes_left == '0, "R6 count at end", bytes_left, 0);
      if (stall && n >= 3) chk(gaps > 0, "R9 line held on starvation", gaps, 1);
      else begin
         chk(gaps == 0, "R8 no gap", gaps, 0);
         chk(on_cycles == expb.size(), "R8 continuous enable", on_cycles, expb.size());
      end
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      #2;
      chk(done_flag == 1'b0, "R7 cleared by done_clr", done_flag, 0);
   endtask

   initial begin
      logic [7:0] pl[$];
      logic [31:0] w;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #2;
      chk(ser_en == 1'b0, "R1 ser_en in reset", ser_en, 0);
      chk(fifo_rd == 1'b0, "R1 fifo_rd in reset", fifo_rd, 0);
      chk(done_flag == 1'b0, "R1 done_flag in reset", done_flag, 0);
      chk(bytes_left == '0, "R1 bytes_left in reset", bytes_left, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(ser_en == 1'b0 && done_flag == 1'b0, "R1 idle after reset", ser_en, 0);

      // R4 known vector "123456789"
      pl = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      run_frame(pl, 1'b0, 1'b0, 1'b0);
      w = '0;
      for (int b = 0; b < 32; b++)
         if (got.size() >= 32) w[b] = got[got.size() - 32 + b];
      chk(w == 32'hCBF4_3926, "R4 known CRC vector", w, 32'hCBF4_3926);

      // R10 empty payload, with and without FCS
      pl.delete();
      run_frame(pl, 1'b0, 1'b0, 1'b0);
      chk(got.size() == 96, "R10 empty frame with fcs", got.size(), 96);
      run_frame(pl, 1'b1, 1'b0, 1'b0);
      chk(got.size() == 64, "R10 empty frame inhibited", got.size(), 64);

      // R5 software CRC passes through as payload tail
      pl = '{8'hA5, 8'h01, 8'hFF, 8'h00, 8'h7E, 8'h12, 8'h34, 8'h56};
      run_frame(pl, 1'b1, 1'b0, 1'b0);

      // R9 starvation, R8 start poke while busy
      pl = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60};
      run_frame(pl, 1'b0, 1'b1, 1'b0);
      run_frame(pl, 1'b1, 1'b0, 1'b1);

      // constrained random frames
      for (int fr = 0; fr < 14; fr++) begin
         int len;
         len = $urandom_range(0, 40);
         pl.delete();
         for (int i = 0; i < len; i++) pl.push_back(8'($urandom_range(0, 255)));
         run_frame(pl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                   1'($urandom_range(0, 2) == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule